// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs the two-wire management bus that a MAC uses to reach the registers of an Ethernet PHY. Software launches a transaction with a single write to a packed 32-bit frame register. That write carries the start code, opcode, turnaround, PHY address, register address and a 16-bit data field. The block then serialises the frame on the management clock and data lines, most significant bit first. By default a 32-bit preamble of ones goes out ahead of the frame. For a read, the block releases the data line at the turnaround and captures the 16 bits the PHY returns into the low half of the same frame register.

Completion is reported by a sticky event flag, not by a busy handshake. Software clears the flag by writing a one to it. The management clock comes from the system clock through a programmable speed register. A speed of zero stops the clock and holds any requested frame until a usable speed is written.

Top module: `mdio_master`

## Requirements
- R1: After reset the frame register and the event flag read zero, the speed register reads zero, `mdc` is low and `mdio_oe` is low.
- R2: Frame register layout: bits 31:30 start, bits 29:28 opcode, bits 27:23 PHY address, bits 22:18 register address, bits 17:16 turnaround, bits 15:0 data. A write frame (opcode 01) places all 32 bits on the line MSB first, each bit sampled at a rising `mdc`. The frame register is unchanged when the frame completes.
- R3: A read frame (opcode 10) drives only bits 31:18. `mdio_oe` is low for the two turnaround bits and all 16 data bits.
- R4: During a read the block samples `mdio_i` on each of the 16 rising `mdc` edges after the turnaround. When the frame ends, the frame register holds those bits in 15:0, first bit in bit 15, with bits 31:16 unchanged.
- R5: The event flag `evt_mii` sets when a frame completes and stays set. A write with `evt_wbit`=1 clears it; a write with `evt_wbit`=0 leaves it set.
- R6: The speed register holds a divider value N in bits 6:1. The `mdc` period is 2*N system clock cycles.
- R7: With N=0, `mdc` stays low and a requested frame stays pending with nothing driven. It starts once N becomes nonzero.
- R8: Speed register bit 7 suppresses the preamble. Cleared (the reset value), 32 ones precede the frame. Set, the frame starts directly with the start bits.
- R9: A frame register write that arrives while a frame is pending or in progress is ignored. The register and the frame on the line keep the first value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_we | input | 1 | Write strobe for the frame register |
| data_wdata | input | 32 | Frame register write value |
| evt_we | input | 1 | Write strobe for the event flag |
| evt_wbit | input | 1 | Event write value; one clears the flag |
| speed_we | input | 1 | Write strobe for the speed register |
| speed_wdata | input | 8 | Speed register write value |
| mdio_i | input | 1 | Management data from the line |
| data_q | output | 32 | Frame register contents |
| evt_mii | output | 1 | Sticky frame-complete flag |
| speed_q | output | 8 | Speed register contents |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | Output enable for `mdio_o` |

## Verification
The hardest case to reach is a frame register write landing in the middle of a frame that is already on the line. The scenario launches one write frame, waits a few dozen cycles until the preamble is clearly under way, and then issues a second write with a different word. It then checks both the register contents and the complete bit stream captured on rising `mdc`. The held-pending case is reached the same way: the scenario zeroes the speed before issuing the write and restores it only after a long wait with the line idle.

// File: rtl/mdio_pkg.sv
// Shared constants and types for the management frame master.
// Assumes a fixed 32-bit frame word with a 16-bit data field at the bottom.
package mdio_pkg;
    localparam int FRAME_W = 32;
    localparam int RD_W    = 16;
    localparam int OP_HI   = 29;
    localparam int OP_LO   = 28;
    localparam int TA_HI   = 17;
    localparam logic [1:0] OP_READ = 2'b10;

    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_PRE   = 2'd1,
        SH_FRAME = 2'd2
    } sh_state_t;
endpackage

// File: rtl/mdio_clkgen.sv
// Management clock divider.
// Toggles mdc every SPD system cycles (period 2*SPD) and emits single-cycle
// rise/fall ticks in the same cycle the mdc register changes.
// Assumes spd may change at any time; a zero value parks mdc low.
module mdio_clkgen #(
    parameter int SPD_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SPD_W-1:0] spd,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [SPD_W-1:0] cnt_q;
    logic             tick;

    // Terminal count reached with a usable divider.
    assign tick      = (spd != '0) && (cnt_q >= spd - 1'b1);
    assign rise_tick = tick && !mdc;
    assign fall_tick = tick && mdc;

    // Divider counter and clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (spd == '0) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_shifter.sv
// Frame serialiser and read-data capture.
// Launches on a falling tick when a request is pending, sends the optional
// preamble, then the 32-bit word MSB first. Output bits change on falling
// ticks; read data is sampled on rising ticks. Assumes ticks from mdio_clkgen.
module mdio_shifter
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_req,
    input  logic [FRAME_W-1:0] word,
    input  logic               no_pre,
    input  logic               rise_tick,
    input  logic               fall_tick,
    input  logic               mdio_i,
    output logic               start_ack,
    output logic               done,
    output logic               is_rd,
    output logic               active,
    output logic [RD_W-1:0]    rd_capt,
    output logic               mdio_o,
    output logic               mdio_oe
);
    localparam int PRE_CW = $clog2(PRE_LEN);
    localparam int IDX_W  = $clog2(FRAME_W);
    localparam int RD_IW  = $clog2(RD_W);

    sh_state_t          st_q;
    logic [PRE_CW-1:0]  pre_q;
    logic [IDX_W-1:0]   idx_q;
    logic [FRAME_W-1:0] sr_q;
    logic               released;

    assign active    = (st_q != SH_IDLE);
    assign is_rd     = (sr_q[OP_HI:OP_LO] == OP_READ);
    assign start_ack = (st_q == SH_IDLE) && start_req && fall_tick;
    assign done      = (st_q == SH_FRAME) && fall_tick && (idx_q == '0);
    assign released  = is_rd && (int'(idx_q) <= TA_HI);

    // Line drivers derived from the current state and bit position.
    always_comb begin
        mdio_o  = 1'b0;
        mdio_oe = 1'b0;
        case (st_q)
            SH_PRE: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b1;
            end
            SH_FRAME: begin
                mdio_o  = sr_q[idx_q];
                mdio_oe = !released;
            end
            default: ;
        endcase
    end

    // Frame sequencing on falling ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SH_IDLE;
            pre_q <= '0;
            idx_q <= '0;
            sr_q  <= '0;
        end else begin
            case (st_q)
                SH_IDLE: begin
                    if (start_ack) begin
                        sr_q  <= word;
                        idx_q <= IDX_W'(FRAME_W - 1);
                        pre_q <= PRE_CW'(PRE_LEN - 1);
                        st_q  <= no_pre ? SH_FRAME : SH_PRE;
                    end
                end
                SH_PRE: begin
                    if (fall_tick) begin
                        if (pre_q == '0) st_q <= SH_FRAME;
                        else             pre_q <= pre_q - 1'b1;
                    end
                end
                SH_FRAME: begin
                    if (fall_tick) begin
                        if (idx_q == '0) st_q <= SH_IDLE;
                        else             idx_q <= idx_q - 1'b1;
                    end
                end
                default: st_q <= SH_IDLE;
            endcase
        end
    end

    // Read data capture on rising ticks inside the data field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_capt <= '0;
        end else if (rise_tick && st_q == SH_FRAME && is_rd && int'(idx_q) < RD_W) begin
            rd_capt[idx_q[RD_IW-1:0]] <= mdio_i;
        end
    end
endmodule

// File: rtl/mdio_regs.sv
// Software-visible state: frame register, sticky event flag, speed register,
// and the pending-request latch. Assumes single-cycle write strobes.
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int SPEED_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               data_we,
    input  logic [FRAME_W-1:0] data_wdata,
    input  logic               evt_we,
    input  logic               evt_wbit,
    input  logic               speed_we,
    input  logic [SPEED_W-1:0] speed_wdata,
    input  logic               start_ack,
    input  logic               done,
    input  logic               done_rd,
    input  logic               active,
    input  logic [RD_W-1:0]    rd_capt,
    output logic [FRAME_W-1:0] data_q,
    output logic               evt_mii,
    output logic [SPEED_W-1:0] speed_q,
    output logic               pending,
    output logic               busy
);
    logic accept;

    assign busy   = pending || active;
    assign accept = data_we && !busy;

    // Frame register: load on accepted write, merge read data at completion.
    always_ff @(posedge clk) begin
        if (!rst_n)                data_q <= '0;
        else if (accept)           data_q <= data_wdata;
        else if (done && done_rd)  data_q[RD_W-1:0] <= rd_capt;
    end

    // Pending request: set by accepted write, cleared when the frame launches.
    always_ff @(posedge clk) begin
        if (!rst_n)         pending <= 1'b0;
        else if (accept)    pending <= 1'b1;
        else if (start_ack) pending <= 1'b0;
    end

    // Sticky completion flag with write-one-to-clear; completion wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                   evt_mii <= 1'b0;
        else if (done)                evt_mii <= 1'b1;
        else if (evt_we && evt_wbit)  evt_mii <= 1'b0;
    end

    // Speed and preamble control register.
    always_ff @(posedge clk) begin
        if (!rst_n)        speed_q <= '0;
        else if (speed_we) speed_q <= speed_wdata;
    end
endmodule

// File: rtl/mdio_master.sv
// Top level of the management frame master: register file, clock divider
// and frame serialiser. Speed register: bits SPD_W:1 divider, bit SPD_W+1
// preamble suppress, bit 0 stored only.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int SPD_W   = 6,
    parameter int PRE_LEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               data_we,
    input  logic [31:0]        data_wdata,
    input  logic               evt_we,
    input  logic               evt_wbit,
    input  logic               speed_we,
    input  logic [SPD_W+1:0]   speed_wdata,
    input  logic               mdio_i,
    output logic [31:0]        data_q,
    output logic               evt_mii,
    output logic [SPD_W+1:0]   speed_q,
    output logic               mdc,
    output logic               mdio_o,
    output logic               mdio_oe
);
    localparam int SPEED_W = SPD_W + 2;

    logic             rise_tick, fall_tick;
    logic             start_ack, frame_done, done_rd, active;
    logic             pending, busy;
    logic [RD_W-1:0]  rd_capt;
    logic [SPD_W-1:0] spd;
    logic             no_pre;

    assign spd    = speed_q[SPD_W:1];
    assign no_pre = speed_q[SPD_W+1];

    mdio_regs #(.SPEED_W(SPEED_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_we     (data_we),
        .data_wdata  (data_wdata),
        .evt_we      (evt_we),
        .evt_wbit    (evt_wbit),
        .speed_we    (speed_we),
        .speed_wdata (speed_wdata),
        .start_ack   (start_ack),
        .done        (frame_done),
        .done_rd     (done_rd),
        .active      (active),
        .rd_capt     (rd_capt),
        .data_q      (data_q),
        .evt_mii     (evt_mii),
        .speed_q     (speed_q),
        .pending     (pending),
        .busy        (busy)
    );

    mdio_clkgen #(.SPD_W(SPD_W)) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .spd       (spd),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_shifter #(.PRE_LEN(PRE_LEN)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (pending),
        .word      (data_q),
        .no_pre    (no_pre),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .start_ack (start_ack),
        .done      (frame_done),
        .is_rd     (done_rd),
        .active    (active),
        .rd_capt   (rd_capt),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );
endmodule

// File: rtl/mdio_master_chk.sv
// Temporal checks on the management frame master, bound to every instance.
module mdio_master_chk #(
    parameter int SPD_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SPD_W-1:0] spd,
    input logic             mdc,
    input logic             pending,
    input logic             busy,
    input logic             frame_done,
    input logic             evt_mii,
    input logic             evt_we,
    input logic             evt_wbit,
    input logic             data_we,
    input logic [31:0]      data_q
);
    AST_MDC_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (spd == '0) |=> !mdc); // R7
    AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (spd == '0 && pending) |=> pending); // R7
    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> evt_mii); // R5
    AST_EVT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_we && evt_wbit && !frame_done) |=> !evt_mii); // R5
    AST_BUSY_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && busy && !frame_done) |=> (data_q == $past(data_q))); // R9
endmodule

bind mdio_master mdio_master_chk #(.SPD_W(SPD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .spd        (spd),
    .mdc        (mdc),
    .pending    (pending),
    .busy       (busy),
    .frame_done (frame_done),
    .evt_mii    (evt_mii),
    .evt_we     (evt_we),
    .evt_wbit   (evt_wbit),
    .data_we    (data_we),
    .data_q     (data_q)
);

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        data_we = 1'b0;
    logic [31:0] data_wdata = '0;
    logic        evt_we = 1'b0;
    logic        evt_wbit = 1'b0;
    logic        speed_we = 1'b0;
    logic [7:0]  speed_wdata = '0;
    logic        mdio_i = 1'b1;
    logic [31:0] data_q;
    logic        evt_mii;
    logic [7:0]  speed_q;
    logic        mdc, mdio_o, mdio_oe;

    int n_chk = 0;
    int n_err = 0;
    logic [0:127] lb;
    int ln = 0;
    int zc = 0;
    logic [15:0] phy_val = 16'hA5C3;
    longint cyc = 0;
    longint prev_rise = 0;
    longint per = 0;

    always #2.5 clk = ~clk;

    mdio_master u_dut (
        .clk(clk), .rst_n(rst_n), .data_we(data_we), .data_wdata(data_wdata),
        .evt_we(evt_we), .evt_wbit(evt_wbit), .speed_we(speed_we),
        .speed_wdata(speed_wdata), .mdio_i(mdio_i), .data_q(data_q),
        .evt_mii(evt_mii), .speed_q(speed_q), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe)
    );

    always @(posedge clk) cyc++;

    // Line monitor and simple PHY responder, both on rising mdc.
    always @(posedge mdc) begin
        per = cyc - prev_rise;
        prev_rise = cyc;
        if (mdio_oe) begin
            if (ln < 128) lb[ln] = mdio_o;
            ln++;
            zc = 0;
            mdio_i = 1'b1;
        end else begin
            zc++;
            if (zc >= 2 && zc <= 17) mdio_i = phy_val[17 - zc];
            else                     mdio_i = 1'b1;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_data(input logic [31:0] w);
        @(negedge clk); data_we = 1'b1; data_wdata = w;
        @(negedge clk); data_we = 1'b0;
    endtask

    task automatic wr_evt(input logic b);
        @(negedge clk); evt_we = 1'b1; evt_wbit = b;
        @(negedge clk); evt_we = 1'b0;
    endtask

    task automatic wr_speed(input logic nopre, input int n);
        @(negedge clk); speed_we = 1'b1; speed_wdata = {nopre, 6'(n), 1'b0};
        @(negedge clk); speed_we = 1'b0;
    endtask

    task automatic wait_evt(input string tag);
        int k;
        k = 0;
        while (!evt_mii && k < 5000) begin @(negedge clk); k++; end
        check(evt_mii, {tag, " completion timeout"}, evt_mii, 1);
    endtask

    // Compare captured driven bits against preamble plus top nb bits of w.
    task automatic check_wire(input logic [31:0] w, input int npre, input int nb, input string tag);
        int bad;
        bad = 0;
        check(ln == npre + nb, {tag, " driven bit count"}, ln, npre + nb);
        for (int i = 0; i < npre; i++) if (lb[i] !== 1'b1) bad++;
        for (int i = 0; i < nb; i++) if (lb[npre + i] !== w[31 - i]) bad++;
        check(bad == 0, {tag, " driven bit values"}, bad, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(data_q == 0, "R1 data_q", data_q, 0);
        check(evt_mii == 0, "R1 evt_mii", evt_mii, 0);
        check(speed_q == 0, "R1 speed_q", speed_q, 0);
        check(mdc == 0, "R1 mdc", mdc, 0);
        check(mdio_oe == 0, "R1 mdio_oe", mdio_oe, 0);
    endtask

    task automatic t_write;
        logic [31:0] w;
        w = {2'b01, 2'b01, 5'h15, 5'h0A, 2'b10, 16'h1234};
        wr_speed(1'b0, 2);
        ln = 0;
        wr_data(w);
        wait_evt("R2");
        check_wire(w, 32, 32, "R2/R8 write frame");
        check(data_q == w, "R2 data_q unchanged", data_q, w);
    endtask

    task automatic t_read;
        logic [31:0] w;
        w = {2'b01, 2'b10, 5'd3, 5'd17, 2'b11, 16'h0000};
        wr_evt(1'b1);
        ln = 0;
        wr_data(w);
        wait_evt("R3");
        check_wire(w, 32, 14, "R3 read frame release");
        check(data_q == {w[31:16], phy_val}, "R4 read capture", data_q, {w[31:16], phy_val});
    endtask

    task automatic t_w1c;
        wr_evt(1'b0);
        @(negedge clk);
        check(evt_mii == 1, "R5 write zero keeps flag", evt_mii, 1);
        wr_evt(1'b1);
        @(negedge clk);
        check(evt_mii == 0, "R5 write one clears flag", evt_mii, 0);
    endtask

    task automatic t_period;
        repeat (30) @(negedge clk);
        check(per == 4, "R6 period N=2", per, 4);
        wr_speed(1'b0, 3);
        repeat (40) @(negedge clk);
        check(per == 6, "R6 period N=3", per, 6);
    endtask

    task automatic t_stop;
        logic [31:0] w;
        w = {2'b01, 2'b01, 5'h01, 5'h02, 2'b10, 16'hBEEF};
        wr_speed(1'b0, 0);
        repeat (5) @(negedge clk);
        ln = 0;
        wr_data(w);
        repeat (300) @(negedge clk);
        check(mdc == 0, "R7 mdc parked", mdc, 0);
        check(evt_mii == 0 && ln == 0, "R7 frame held", ln, 0);
        wr_speed(1'b0, 2);
        wait_evt("R7");
        check_wire(w, 32, 32, "R7 released frame");
    endtask

    task automatic t_nopre;
        logic [31:0] w;
        w = {2'b01, 2'b01, 5'h1F, 5'h00, 2'b10, 16'h8001};
        wr_evt(1'b1);
        wr_speed(1'b1, 2);
        ln = 0;
        wr_data(w);
        wait_evt("R8");
        check_wire(w, 0, 32, "R8 no preamble");
        wr_speed(1'b0, 2);
    endtask

    task automatic t_busy;
        logic [31:0] w1, w2;
        w1 = {2'b01, 2'b01, 5'h0C, 5'h13, 2'b10, 16'hC0DE};
        w2 = {2'b01, 2'b10, 5'h02, 5'h04, 2'b11, 16'hFFFF};
        wr_evt(1'b1);
        ln = 0;
        wr_data(w1);
        repeat (40) @(negedge clk);
        wr_data(w2);
        @(negedge clk);
        check(data_q == w1, "R9 write during frame ignored", data_q, w1);
        wait_evt("R9");
        check_wire(w1, 32, 32, "R9 frame kept");
        check(data_q == w1, "R9 data_q after frame", data_q, w1);
    endtask

    initial begin
        #500000;
        n_err++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write();
        t_read();
        t_w1c();
        t_period();
        t_stop();
        t_nopre();
        t_busy();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end
endmodule